// File: doc/BRIEF.md
# Sticky Device Status Flag Register

This block keeps the eight-bit status byte that a host reads with the status query command. Each bit follows its own lifetime rule. One bit simply mirrors whether any key is detecting right now. A group of error bits latch when their error event arrives and stay latched until the chip is reset or the host sends the clear command directly after the status command. Two derived bits summarise the per-key extreme-signal and calibration-error flags, and only a completed recalibration can drop them. A built-in watchdog latches a sync-loss error when sync pulses stop for too long, and that bit stays set after the pulses come back.

The block snoops every valid command byte from the serial front end to spot the two-byte clear sequence. It does not answer commands itself. The registered status byte is handed to whatever builds the response. A registered major-error output summarises the error classes that downstream logic treats as severe.

Top module: `devstat_reg`

## Requirements
- R1: While `rst` is high at a clock edge, `status` becomes 0x20 and `major_err` becomes 0 at that edge.
- R2: Bit 7 of `status` is 1 exactly when at least one bit of `key_active` was 1 at the previous clock edge. It is volatile and drops on its own once no key is active.
- R3: A high `eep_fail_stb`, `eep_crc_stb` or `ram_crc_stb` sampled at an edge sets bit 6, bit 2 or bit 1 respectively at that edge. The bit then holds with no further strobes.
- R4: Bit 5 reads 1 after every reset. Nothing but reset sets it, and only the clear sequence drops it.
- R5: The clear sequence is a valid `cmd_byte` of 0xC7 whose previous valid byte was 0xC2. Cycles without `cmd_valid` may lie in between. It clears bits 6, 5, 3, 2 and 1 at the edge where 0xC7 is sampled. A different valid byte between the two disarms the sequence.
- R6: A set condition for a sticky bit in the same cycle as the clear sequence leaves that bit at 1.
- R7: Bit 4 is set whenever any bit of `key_extreme` is high. Once set, it clears only at an edge where `recal_done` is high and all of `key_extreme` is low. The clear sequence does not touch it.
- R8: Bit 0 is set whenever any bit of `key_calerr` is high. Once set, it clears only at an edge where `recal_done` is high and all of `key_calerr` is low.
- R9: The sync watchdog restarts on every sampled `sync_pulse`. Bit 3 is 1 from the (SYNC_TIMEOUT+1)-th edge after the last sampled pulse when no pulse came in between. It stays 1 after pulses return, until the clear sequence or reset.
- R10: `major_err` equals the OR of `status` bits 4, 2, 1 and 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_active | input | NUM_KEYS | Live per-key detect indication |
| key_extreme | input | NUM_KEYS | Per-key out-of-bounds signal flags |
| key_calerr | input | NUM_KEYS | Per-key calibration error flags |
| eep_fail_stb | input | 1 | Setup memory missing or invalid event |
| eep_crc_stb | input | 1 | Setup memory checksum mismatch event |
| ram_crc_stb | input | 1 | Working setup checksum mismatch event |
| sync_pulse | input | 1 | Sync pulse, one cycle per pulse |
| recal_done | input | 1 | Recalibration finished strobe |
| cmd_valid | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Incoming command byte |
| status | output | 8 | Registered status byte |
| major_err | output | 1 | Registered major-error summary |

## Verification
The bench builds the block with ten keys, as in the default, and a sync timeout of 40 cycles in place of the default one-second count. The short timeout lets the run reach the sync-loss edge, hold pulses off past it, resume them and clear the latch within a few hundred cycles. The per-cycle reference model then covers the exact timeout boundary. The ten-key width lets the flags on the highest key, key 9, and on several keys at once be driven to the summary bits.

// File: rtl/devstat_pkg.sv
package devstat_pkg;
  // bit positions; the response byte layout depends on them
  localparam int BIT_ACTIVE = 7;
  localparam int BIT_EEP    = 6;
  localparam int BIT_RSTEV  = 5;
  localparam int BIT_EXT    = 4;
  localparam int BIT_SYNC   = 3;
  localparam int BIT_EEPCRC = 2;
  localparam int BIT_RAMCRC = 1;
  localparam int BIT_CAL    = 0;

  localparam int STAT_W = 8;

  localparam logic [STAT_W-1:0] STICKY_MASK = 8'b0110_1110;
  localparam logic [STAT_W-1:0] MAJOR_MASK  = 8'b0001_0111;
  localparam logic [STAT_W-1:0] RESET_VALUE = 8'b0010_0000;
endpackage

// File: rtl/devstat_clrseq.sv
module devstat_clrseq #(
  parameter logic [7:0] LEAD_CODE = 8'hC2,
  parameter logic [7:0] TAIL_CODE = 8'hC7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       clr_hit
);
  logic armed;

  // armed tracks whether the most recent valid byte was the lead code
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (cmd_valid) begin
      armed <= (cmd_byte == LEAD_CODE);
    end
  end

  assign clr_hit = cmd_valid && armed && (cmd_byte == TAIL_CODE);
endmodule

// File: rtl/devstat_syncwd.sv
module devstat_syncwd #(
  parameter int TIMEOUT = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_pulse,
  output logic lost
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] gap_cnt;

  // counts cycles since last pulse, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (sync_pulse) begin
      gap_cnt <= '0;
    end else if (gap_cnt != LIMIT) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign lost = (gap_cnt == LIMIT);
endmodule

// File: rtl/devstat_flags.sv
module devstat_flags
  import devstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active_any,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_hit,
  input  logic              ext_any,
  input  logic              cal_any,
  input  logic              recal_done,
  output logic [STAT_W-1:0] status,
  output logic              major_err
);
  logic [STAT_W-1:0] nxt;

  // per-bit next-state rule picked by the bit's class
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      // set has priority over the clear sequence
      assign nxt[i] = set_vec[i] | (status[i] & ~clr_hit);
    end else if (i == BIT_ACTIVE) begin : g_live
      assign nxt[i] = active_any;
    end else if (i == BIT_EXT) begin : g_ext
      assign nxt[i] = ext_any | (status[i] & ~recal_done);
    end else if (i == BIT_CAL) begin : g_cal
      assign nxt[i] = cal_any | (status[i] & ~recal_done);
    end else begin : g_unused
      assign nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= RESET_VALUE;
      major_err <= |(RESET_VALUE & MAJOR_MASK);
    end else begin
      status    <= nxt;
      major_err <= |(nxt & MAJOR_MASK);
    end
  end
endmodule

// File: rtl/devstat_reg.sv
module devstat_reg
  import devstat_pkg::*;
#(
  parameter int         NUM_KEYS     = 10,
  parameter int         SYNC_TIMEOUT = 100_000_000,
  parameter logic [7:0] CMD_STATUS   = 8'hC2,
  parameter logic [7:0] CMD_CLEAR    = 8'hC7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_active,
  input  logic [NUM_KEYS-1:0] key_extreme,
  input  logic [NUM_KEYS-1:0] key_calerr,
  input  logic                eep_fail_stb,
  input  logic                eep_crc_stb,
  input  logic                ram_crc_stb,
  input  logic                sync_pulse,
  input  logic                recal_done,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_byte,
  output logic [STAT_W-1:0]   status,
  output logic                major_err
);
  logic              clr_hit;
  logic              sync_lost;
  logic [STAT_W-1:0] set_vec;

  devstat_clrseq #(
    .LEAD_CODE (CMD_STATUS),
    .TAIL_CODE (CMD_CLEAR)
  ) i_clrseq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .clr_hit   (clr_hit)
  );

  devstat_syncwd #(
    .TIMEOUT (SYNC_TIMEOUT)
  ) i_syncwd (
    .clk        (clk),
    .rst        (rst),
    .sync_pulse (sync_pulse),
    .lost       (sync_lost)
  );

  // route event sources onto their sticky bit positions
  always_comb begin
    set_vec             = '0;
    set_vec[BIT_EEP]    = eep_fail_stb;
    set_vec[BIT_SYNC]   = sync_lost;
    set_vec[BIT_EEPCRC] = eep_crc_stb;
    set_vec[BIT_RAMCRC] = ram_crc_stb;
  end

  devstat_flags i_flags (
    .clk        (clk),
    .rst        (rst),
    .active_any (|key_active),
    .set_vec    (set_vec),
    .clr_hit    (clr_hit),
    .ext_any    (|key_extreme),
    .cal_any    (|key_calerr),
    .recal_done (recal_done),
    .status     (status),
    .major_err  (major_err)
  );
endmodule

// File: rtl/devstat_checker.sv
module devstat_checker
  import devstat_pkg::*;
#(
  parameter int         NUM_KEYS  = 10,
  parameter logic [7:0] CMD_CLEAR = 8'hC7
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_KEYS-1:0] key_active,
  input logic                recal_done,
  input logic                cmd_valid,
  input logic [7:0]          cmd_byte,
  input logic [STAT_W-1:0]   status,
  input logic                major_err
);
  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (status == RESET_VALUE) && !major_err);

  p_live_bit_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> status[BIT_ACTIVE] == $past(|key_active));

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_byte == CMD_CLEAR)
      |=> ((status & $past(status) & STICKY_MASK) == ($past(status) & STICKY_MASK)));

  p_rst_flag_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
    !status[BIT_RSTEV] |=> !status[BIT_RSTEV]);

  p_ext_hold_r7: assert property (@(posedge clk) disable iff (rst)
    status[BIT_EXT] && !recal_done |=> status[BIT_EXT]);

  p_cal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    status[BIT_CAL] && !recal_done |=> status[BIT_CAL]);

  p_major_match_r10: assert property (@(posedge clk) disable iff (rst)
    major_err == |(status & MAJOR_MASK));
endmodule

bind devstat_reg devstat_checker #(
  .NUM_KEYS  (NUM_KEYS),
  .CMD_CLEAR (CMD_CLEAR)
) i_devstat_checker (
  .clk        (clk),
  .rst        (rst),
  .key_active (key_active),
  .recal_done (recal_done),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .status     (status),
  .major_err  (major_err)
);

// File: tb/test_devstat_reg.sv
`timescale 1ns/1ps
module test_devstat_reg;
  localparam int NK = 10;
  localparam int TO = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [NK-1:0] key_active, key_extreme, key_calerr;
  logic          eep_fail_stb, eep_crc_stb, ram_crc_stb;
  logic          sync_pulse, recal_done, cmd_valid;
  logic [7:0]    cmd_byte;
  logic [7:0]    status;
  logic          major_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit sync_en = 1'b0;
  int sync_ctr = 0;

  always #5 clk = ~clk;

  devstat_reg #(.NUM_KEYS(NK), .SYNC_TIMEOUT(TO)) i_devstat_reg (
    .clk(clk), .rst(rst), .key_active(key_active), .key_extreme(key_extreme),
    .key_calerr(key_calerr), .eep_fail_stb(eep_fail_stb), .eep_crc_stb(eep_crc_stb),
    .ram_crc_stb(ram_crc_stb), .sync_pulse(sync_pulse), .recal_done(recal_done),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .status(status), .major_err(major_err)
  );

  // behavioural reference model
  logic [7:0] m_stat = 8'h20;
  bit   m_major = 1'b0;
  bit   m_valid = 1'b0;
  bit   m_last_was_c2 = 1'b0;
  int   m_gap = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_stat = 8'h20; m_major = 1'b0; m_last_was_c2 = 1'b0; m_gap = 0; m_valid = 1'b1;
    end else if (m_valid) begin
      bit clr, lost;
      logic [7:0] n;
      clr  = cmd_valid && cmd_byte == 8'hC7 && m_last_was_c2;
      if (cmd_valid) m_last_was_c2 = (cmd_byte == 8'hC2);
      lost = (m_gap >= TO);
      if (sync_pulse) m_gap = 0; else if (m_gap < TO) m_gap = m_gap + 1;
      n = m_stat;
      n[7] = (key_active != 0);
      if (clr) begin n[6] = 0; n[5] = 0; n[3] = 0; n[2] = 0; n[1] = 0; end
      if (eep_fail_stb) n[6] = 1;
      if (eep_crc_stb)  n[2] = 1;
      if (ram_crc_stb)  n[1] = 1;
      if (lost)         n[3] = 1;
      if (key_extreme != 0) n[4] = 1; else if (recal_done) n[4] = 0;
      if (key_calerr != 0)  n[0] = 1; else if (recal_done) n[0] = 0;
      m_stat  = n;
      m_major = n[4] | n[2] | n[1] | n[0];
    end
  end

  function automatic string req_of(logic [7:0] d);
    if (d[7]) return "R2";
    if (d[5]) return "R4";
    if (d[4]) return "R7";
    if (d[3]) return "R9";
    if (d[0]) return "R8";
    return "R3";
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid) begin
      checks++;
      if (status !== m_stat) begin
        errors++;
        $display("FAIL %s: status got %h expected %h (cycle %0d)",
                 req_of(status ^ m_stat), status, m_stat, cyc);
      end
      checks++;
      if (major_err !== m_major) begin
        errors++;
        $display("FAIL R10: major_err got %b expected %b (cycle %0d)", major_err, m_major, cyc);
      end
    end
  end

  // background sync source, a pulse every 8 cycles
  always @(negedge clk) begin
    if (sync_en) begin
      sync_ctr++;
      sync_pulse = (sync_ctr % 8 == 0);
    end else begin
      sync_pulse = 1'b0;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 20000", cyc);
      finish_run();
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(string tag, int b, logic expv);
    checks++;
    if (status[b] !== expv) begin
      errors++;
      $display("FAIL %s: status[%0d] got %b expected %b", tag, b, status[b], expv);
    end
  endtask

  task automatic chk_byte(string tag, logic [7:0] mask, logic [7:0] expv);
    checks++;
    if ((status & mask) !== expv) begin
      errors++;
      $display("FAIL %s: status&%h got %h expected %h", tag, mask, status & mask, expv);
    end
  endtask

  task automatic chk_major(string tag, logic expv);
    checks++;
    if (major_err !== expv) begin
      errors++;
      $display("FAIL %s: major_err got %b expected %b", tag, major_err, expv);
    end
  endtask

  task automatic send(logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b; step(); cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic pulse_recal();
    recal_done = 1'b1; step(); recal_done = 1'b0;
  endtask

  initial begin
    rst = 1'b1; key_active = '0; key_extreme = '0; key_calerr = '0;
    eep_fail_stb = 0; eep_crc_stb = 0; ram_crc_stb = 0; sync_pulse = 0;
    recal_done = 0; cmd_valid = 0; cmd_byte = 8'h00;
    step(3);
    chk_byte("R1", 8'hFF, 8'h20);
    chk_major("R1", 1'b0);
    rst = 1'b0; sync_en = 1'b1;
    step();
    chk_bit("R4", 5, 1'b1);

    // live detect bit
    key_active = 10'h001; step(); chk_bit("R2", 7, 1'b1);
    key_active = 10'h200; step(); chk_bit("R2", 7, 1'b1);
    key_active = '0;      step(); chk_bit("R2", 7, 1'b0);

    // sticky error strobes
    eep_fail_stb = 1; step(); eep_fail_stb = 0; step(2); chk_bit("R3", 6, 1'b1);
    ram_crc_stb = 1;  step(); ram_crc_stb = 0;  step(); chk_bit("R3", 1, 1'b1);
    chk_major("R10", 1'b1);
    eep_crc_stb = 1;  step(); eep_crc_stb = 0;  step(); chk_bit("R3", 2, 1'b1);

    // interrupted sequence must not clear
    send(8'hC2); send(8'h55); send(8'hC7); step();
    chk_byte("R5", 8'h66, 8'h66);
    send(8'hC7); step();
    chk_byte("R5", 8'h66, 8'h66);

    // sequence with idle gap clears
    send(8'hC2); step(2); send(8'hC7);
    chk_byte("R5", 8'h6E, 8'h00);
    chk_bit("R4", 5, 1'b0);
    chk_major("R10", 1'b0);

    // set wins over same-cycle clear
    send(8'hC2);
    ram_crc_stb = 1; send(8'hC7); ram_crc_stb = 0;
    chk_bit("R6", 1, 1'b1);
    send(8'hC2); send(8'hC7);
    chk_bit("R5", 1, 1'b0);

    // extreme-signal summary
    key_extreme = 10'h008; step(); chk_bit("R7", 4, 1'b1); chk_major("R10", 1'b1);
    key_extreme = '0; step(2); chk_bit("R7", 4, 1'b1);
    send(8'hC2); send(8'hC7); chk_bit("R7", 4, 1'b1);
    key_extreme = 10'h020; pulse_recal(); key_extreme = '0; chk_bit("R7", 4, 1'b1);
    pulse_recal(); chk_bit("R7", 4, 1'b0);

    // calibration-error summary
    key_calerr = 10'h201; step(); chk_bit("R8", 0, 1'b1);
    key_calerr = 10'h001; pulse_recal(); chk_bit("R8", 0, 1'b1);
    key_calerr = '0; step(3); chk_bit("R8", 0, 1'b1);
    pulse_recal(); chk_bit("R8", 0, 1'b0);

    // sync watchdog
    step(3 * TO); chk_bit("R9", 3, 1'b0);
    sync_en = 1'b0; step(TO / 2); chk_bit("R9", 3, 1'b0);
    step(TO); chk_bit("R9", 3, 1'b1);
    sync_en = 1'b1; step(30); chk_bit("R9", 3, 1'b1);
    send(8'hC2); send(8'hC7); chk_bit("R9", 3, 1'b0);
    step(2 * TO); chk_bit("R9", 3, 1'b0);

    // reset mid-run restores the reset byte
    eep_fail_stb = 1; key_calerr = 10'h100; step(); eep_fail_stb = 0; key_calerr = '0;
    rst = 1'b1; step(); rst = 1'b0;
    chk_byte("R1", 8'hFF, 8'h20); chk_major("R1", 1'b0);
    step(4);
    finish_run();
  end
endmodule